// File: doc/BRIEF.md
# Multi-Lane Serial Converter Word Receiver

This block sits on the receive side of a link from a four-channel, 12-bit data converter. Each channel arrives as a single serial lane, least-significant bit first. A shared frame signal rises once per sample to mark the slot that carries bit 0. Every input is sampled on the bit clock. The block rebuilds one parallel word per lane for each frame and presents the four words together with a one-cycle valid strobe.

An output-coding select chooses how the words are delivered. When the converter sends offset-binary codes, the block turns them into signed two's complement. Otherwise the words pass unchanged. A test-mode input enables a per-lane checker. The checker compares each received word against the fixed pattern 0x0BD and counts mismatches in saturating per-lane counters, which a synchronous clear input resets. A frame edge that arrives before a word is complete sets a sticky alignment-error flag. The partial word is dropped and collection starts again.

Top module: `adc_frame_rx`

## Requirements
- R1: After reset, `wordValid`, `alignErr`, all words and all counters are 0. No word is reported until a rising edge of `frameIn` has been seen. A frame input that is already high when reset is released does not count as an edge.
- R2: The bit sampled in the same cycle as a `frameIn` rising edge is bit 0 of the lane word. The bit sampled k cycles later is bit k, for k from 1 to 11.
- R3: `wordValid` is high for exactly one clock cycle, starting 12 cycles after the frame-edge cycle. In that cycle all four lane words change together. Lane l occupies `wordsOut[12*l+11 : 12*l]`.
- R4: When `offsetBin` is 1, the presented word is the received word with bit 11 inverted, so 0x800 becomes 0x000. When `offsetBin` is 0, the received word is presented unchanged.
- R5: While `testMode` is 1, each completed word that differs from 0x0BD increments that lane's counter by one. The comparison uses the received bits, before coding conversion. A matching word leaves the counter unchanged. While `testMode` is 0, the counters never change except through the clear input.
- R6: A lane counter that has reached its all-ones value stays there on further mismatches.
- R7: `clrCnt` sets all counters to 0 on the next clock edge. When a clear and a counted mismatch fall in the same cycle, the clear wins.
- R8: A rising frame edge that arrives while a word is still being collected sets `alignErr`, which stays set until reset. The partial word produces no `wordValid`, and the new edge starts a fresh word at bit 0.
- R9: Bits that arrive after the 12th bit of a word and before the next rising frame edge produce no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; every input is sampled on its rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| frameIn | input | 1 | Frame signal; its rising edge marks bit 0 |
| serIn | input | LANES | One serial data bit per lane |
| offsetBin | input | 1 | 1: input coding is offset binary; 0: already two's complement |
| testMode | input | 1 | Enables the test-pattern checker |
| clrCnt | input | 1 | Synchronous clear of all mismatch counters |
| wordsOut | output | LANES*WORD_W | Lane words, lane l at bits [WORD_W*l +: WORD_W] |
| wordValid | output | 1 | One-cycle strobe when new words are presented |
| alignErr | output | 1 | Sticky flag for a frame edge inside a word |
| errCnt | output | LANES*CNT_W | Mismatch counters, lane l at bits [CNT_W*l +: CNT_W] |

## Verification
Two events can land on the same clock edge: the capture of a word that the checker counts as a mismatch, and a pulse on the counter clear. The bench raises `clrCnt` exactly in the slot that carries bit 11 of a mismatching test-mode frame. It then expects every counter to read zero. A further mismatching frame must then read one, which shows the clear did not block later counting. A second overlap, a frame edge arriving while a word is still being collected, is provoked by cutting a frame short. The bench then confirms that the flag is set, that no strobe appears for the partial word, and that the restarted word arrives intact. The coding conversion is swept over all 4096 codes, with the computed expected value alternating between the two coding modes.

// File: rtl/adc_rx_pkg.sv
package adc_rx_pkg;

  // Strobes from the frame control to the lane datapath.
  typedef struct packed {
    logic capture;  // last bit of a word is on the lanes this cycle
    logic check;    // capture while the pattern checker is enabled
  } rxStrobe_t;

endpackage

// File: rtl/adc_rx_ctrl.sv
module adc_rx_ctrl
  import adc_rx_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      frameIn,
  input  logic      testMode,
  output rxStrobe_t strb,
  output logic      alignErr
);

  localparam int BIT_CW = $clog2(WORD_W);
  localparam logic [BIT_CW-1:0] LAST_IDX = BIT_CW'(WORD_W - 1);
  localparam logic [BIT_CW-1:0] ONE_IDX  = BIT_CW'(1);

  logic              framePrev;
  logic              frameRise;
  logic              collecting;
  logic [BIT_CW-1:0] bitIdx;
  logic              captureNow;

  assign frameRise  = frameIn & ~framePrev;
  assign captureNow = collecting & ~frameRise & (bitIdx == LAST_IDX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      // a frame already high at reset release is not an edge
      framePrev  <= 1'b1;
      collecting <= 1'b0;
      bitIdx     <= '0;
      alignErr   <= 1'b0;
    end else begin
      framePrev <= frameIn;
      if (frameRise) begin
        if (collecting) alignErr <= 1'b1;
        collecting <= 1'b1;
        bitIdx     <= ONE_IDX;
      end else if (collecting) begin
        if (bitIdx == LAST_IDX) begin
          collecting <= 1'b0;
          bitIdx     <= '0;
        end else begin
          bitIdx <= bitIdx + ONE_IDX;
        end
      end
    end
  end

  always_comb begin
    strb.capture = captureNow;
    strb.check   = captureNow & testMode;
  end

  // R3
  capture_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> !strb.capture);

  // R8
  align_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    alignErr |=> alignErr);

  // R8
  partial_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameRise && collecting) |=> (alignErr && !strb.capture));

  // R9
  idle_no_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!collecting && !frameRise) |-> !strb.capture);

endmodule

// File: rtl/adc_rx_datapath.sv
module adc_rx_datapath
  import adc_rx_pkg::*;
#(
  parameter int          LANES     = 4,
  parameter int          WORD_W    = 12,
  parameter int          CNT_W     = 16,
  parameter logic [11:0] TEST_WORD = 12'h0BD
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [LANES-1:0]        serIn,
  input  logic                    offsetBin,
  input  logic                    clrCnt,
  input  rxStrobe_t               strb,
  output logic [LANES*WORD_W-1:0] wordsOut,
  output logic                    wordValid,
  output logic [LANES*CNT_W-1:0]  errCnt
);

  localparam logic [WORD_W-1:0] MSB_MASK = {1'b1, {(WORD_W-1){1'b0}}};
  localparam logic [WORD_W-1:0] PATTERN  = WORD_W'(TEST_WORD);
  localparam logic [CNT_W-1:0]  CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

  logic [WORD_W-1:0] shiftReg [LANES];
  logic [WORD_W-1:0] rawWord  [LANES];
  logic [WORD_W-1:0] wordReg  [LANES];
  logic [CNT_W-1:0]  laneCnt  [LANES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wordValid <= 1'b0;
    else       wordValid <= strb.capture;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    // LSB first: new bits enter at the top and move toward bit 0
    assign rawWord[l] = {serIn[l], shiftReg[l][WORD_W-1:1]};

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) shiftReg[l] <= '0;
      else       shiftReg[l] <= rawWord[l];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wordReg[l] <= '0;
      end else if (strb.capture) begin
        wordReg[l] <= offsetBin ? (rawWord[l] ^ MSB_MASK) : rawWord[l];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        laneCnt[l] <= '0;
      end else if (clrCnt) begin
        laneCnt[l] <= '0;
      end else if (strb.check && (rawWord[l] != PATTERN) && (laneCnt[l] != CNT_MAX)) begin
        laneCnt[l] <= laneCnt[l] + CNT_ONE;
      end
    end

    assign wordsOut[l*WORD_W +: WORD_W] = wordReg[l];
    assign errCnt[l*CNT_W +: CNT_W]     = laneCnt[l];

    // R6
    cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rstN)
      (laneCnt[l] == CNT_MAX && !clrCnt) |=> laneCnt[l] == CNT_MAX);
  end

  // R5
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.check && !clrCnt) |=> $stable(errCnt));

  // R7
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    clrCnt |=> errCnt == '0);

  // R3
  words_with_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(wordsOut) |-> wordValid);

endmodule

// File: rtl/adc_frame_rx.sv
module adc_frame_rx
  import adc_rx_pkg::*;
#(
  parameter int          LANES     = 4,
  parameter int          WORD_W    = 12,
  parameter int          CNT_W     = 16,
  parameter logic [11:0] TEST_WORD = 12'h0BD
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    frameIn,
  input  logic [LANES-1:0]        serIn,
  input  logic                    offsetBin,
  input  logic                    testMode,
  input  logic                    clrCnt,
  output logic [LANES*WORD_W-1:0] wordsOut,
  output logic                    wordValid,
  output logic                    alignErr,
  output logic [LANES*CNT_W-1:0]  errCnt
);

  rxStrobe_t strb;

  adc_rx_ctrl #(
    .WORD_W(WORD_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .frameIn  (frameIn),
    .testMode (testMode),
    .strb     (strb),
    .alignErr (alignErr)
  );

  adc_rx_datapath #(
    .LANES    (LANES),
    .WORD_W   (WORD_W),
    .CNT_W    (CNT_W),
    .TEST_WORD(TEST_WORD)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .serIn     (serIn),
    .offsetBin (offsetBin),
    .clrCnt    (clrCnt),
    .strb      (strb),
    .wordsOut  (wordsOut),
    .wordValid (wordValid),
    .errCnt    (errCnt)
  );

endmodule

// File: tb/adc_frame_rx_bench.sv
module adc_frame_rx_bench;

  localparam int LANES = 4;
  localparam int WW    = 12;
  localparam int CW    = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rstN, frameIn, offsetBin, testMode, clrCnt;
  logic [LANES-1:0] serIn;
  logic [LANES*WW-1:0] wordsOut;
  logic                wordValid, alignErr;
  logic [LANES*CW-1:0] errCnt;

  adc_frame_rx #(.LANES(LANES), .WORD_W(WW), .CNT_W(CW)) u_adc_frame_rx (
    .clk(clk), .rstN(rstN), .frameIn(frameIn), .serIn(serIn),
    .offsetBin(offsetBin), .testMode(testMode), .clrCnt(clrCnt),
    .wordsOut(wordsOut), .wordValid(wordValid), .alignErr(alignErr),
    .errCnt(errCnt)
  );

  int checks = 0, fails = 0, cyc = 0, vCount = 0, lastStamp = 0, startStamp = 0;
  bit done = 0;
  logic [LANES*WW-1:0] lastWords = '0;
  int model [LANES];

  always @(negedge clk) begin
    cyc++;
    if (wordValid) begin
      vCount++;
      lastStamp = cyc;
      lastWords = wordsOut;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  function automatic logic [WW-1:0] conv(input logic [WW-1:0] v, input bit ob);
    return ob ? (v ^ 12'h800) : v;
  endfunction

  // drives nBits slots of a frame, then one idle slot where wordValid shows
  task automatic sendFrame(input logic [LANES*WW-1:0] w, input int nBits, input bit clrAtLast);
    for (int i = 0; i < nBits; i++) begin
      tick();
      if (i == 0) startStamp = cyc;
      frameIn = (i < 2);
      clrCnt  = clrAtLast && (i == WW - 1);
      for (int l = 0; l < LANES; l++) serIn[l] = w[l*WW + i];
    end
    tick();
    frameIn = 1'b0;
    clrCnt  = 1'b0;
    serIn   = '0;
  endtask

  task automatic checkCounts(input string req);
    for (int l = 0; l < LANES; l++)
      chk(errCnt[l*CW +: CW] == model[l], req, errCnt[l*CW +: CW], model[l]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finishRun();
  end

  initial begin
    logic [LANES*WW-1:0] w;
    int v0;
    rstN = 0; frameIn = 1; serIn = '0; offsetBin = 0; testMode = 0; clrCnt = 0;
    repeat (3) tick();
    rstN = 1;
    tick();
    // R1 reset state
    chk(wordValid == 0 && alignErr == 0, "R1 flags", {wordValid, alignErr}, 0);
    chk(wordsOut == '0, "R1 words", wordsOut, 0);
    chk(errCnt == '0, "R1 counters", errCnt, 0);
    // R1 no word before a real rising edge (frame held high from reset)
    for (int i = 0; i < 30; i++) begin tick(); serIn = LANES'(i); end
    chk(vCount == 0, "R1 no early word", vCount, 0);
    frameIn = 0; tick();

    // R3 timing and pulse width
    w = {12'h123, 12'h456, 12'h789, 12'hABC};
    v0 = vCount;
    sendFrame(w, WW, 0);
    chk(lastStamp - startStamp == 12, "R3 latency", lastStamp - startStamp, 12);
    repeat (3) tick();
    chk(vCount - v0 == 1, "R3 single pulse", vCount - v0, 1);
    chk(lastWords == w, "R2 R3 lane words", lastWords, w);

    // R9 trailing bits without an edge
    v0 = vCount;
    sendFrame(w, WW, 0);
    for (int i = 0; i < 25; i++) begin tick(); serIn = ~serIn; end
    chk(vCount - v0 == 1, "R9 no extra word", vCount - v0, 1);

    // R2 R4 exhaustive sweep over all codes, coding alternates
    for (int v = 0; v < 4096; v++) begin
      logic [WW-1:0] a, b, c, d;
      logic [LANES*WW-1:0] e;
      a = WW'(v); b = ~a; c = a ^ 12'h5A5; d = WW'(v * 7 + 3);
      offsetBin = a[0];
      v0 = vCount;
      sendFrame({d, c, b, a}, WW, 0);
      e = {conv(d, a[0]), conv(c, a[0]), conv(b, a[0]), conv(a, a[0])};
      chk(lastWords == e && vCount - v0 == 1, "R2 R4 sweep", lastWords, e);
    end
    // R5 no counting outside test mode
    for (int l = 0; l < LANES; l++) model[l] = 0;
    checkCounts("R5 idle counters");

    // R5 R6 test mode with saturation (conversion must not affect compare)
    testMode = 1; offsetBin = 1;
    for (int k = 0; k < 20; k++) begin
      logic [WW-1:0] l3;
      l3 = (k % 2 == 1) ? 12'h03D : 12'h0BD;
      sendFrame({l3, 12'h0BD, 12'h0BC, 12'h0BD}, WW, 0);
      if (model[1] < 15) model[1]++;
      if (k % 2 == 1 && model[3] < 15) model[3]++;
    end
    checkCounts("R5 R6 counts");
    chk(model[1] == 15, "R6 saturated model", model[1], 15);

    // R7 clear coinciding with a counted mismatch
    sendFrame('0, WW, 1);
    tick();
    for (int l = 0; l < LANES; l++) model[l] = 0;
    checkCounts("R7 clear wins");
    sendFrame('0, WW, 0);
    for (int l = 0; l < LANES; l++) model[l] = 1;
    checkCounts("R7 counting resumes");
    clrCnt = 1; tick(); clrCnt = 0; tick();
    for (int l = 0; l < LANES; l++) model[l] = 0;
    checkCounts("R7 idle clear");

    // R8 partial frame
    testMode = 0; offsetBin = 0;
    chk(alignErr == 0, "R8 no error yet", alignErr, 0);
    v0 = vCount;
    sendFrame(w, 5, 0);
    w = {12'hFED, 12'h001, 12'h800, 12'h3C3};
    sendFrame(w, WW, 0);
    chk(alignErr == 1, "R8 flag set", alignErr, 1);
    chk(vCount - v0 == 1, "R8 partial dropped", vCount - v0, 1);
    chk(lastWords == w, "R8 restart word", lastWords, w);
    sendFrame(w, WW, 0);
    repeat (3) tick();
    chk(alignErr == 1, "R8 sticky", alignErr, 1);

    finishRun();
  end

endmodule